// File: doc/BRIEF.md
# Flash Block Erase Command Interface

This block is the device-side front end of a small flash array model. It listens to a byte-wide bus qualified by a command-latch strobe, an address-latch strobe and a write strobe. A write-strobe cycle with the command latch high delivers a command byte. A write-strobe cycle with the address latch high delivers an address byte. From these bytes the block recognises a block-erase sequence: a setup byte, three address bytes, then a confirm byte. It then pulls its ready/busy output low while it drives every word of the selected block to all ones, one word at a time.

The block also serves a status register and a reset command. The status register shows controller readiness and the pass/fail result of the last erase. The reset command aborts an erase that is running and leaves that block only partly erased. A reset that arrives when the interface is already in its reset state is dropped. Erase failure can be forced from an input, so the fail path can be exercised.

The array is a parameterised register store of `NUM_BLOCKS` blocks of `WORDS_PER_BLOCK` words. It has a direct load/read port so a host model can fill it and inspect it.

Top module: `flash_erase_ctl`

## Requirements
- R1: After `rst_n` is released, `rb` is 1, `dout` is 0 and every array word holds all ones; a later 70h command makes `dout` read 40h.
- R2: Command 60h opens an erase setup. The next three address bytes form a 24-bit row number, first byte least significant. The block index is bits [6 +: log2(NUM_BLOCKS)] of that row; bits 5..0 and the bits above the index are ignored.
- R3: A D0h command that follows exactly three address bytes after 60h starts the erase: `rb` drops right after that strobe edge and stays low for exactly WORDS_PER_BLOCK*CYC_PER_WORD cycles.
- R4: A completed erase leaves every word of the selected block at all ones and every other block unchanged. Words are cleared in ascending order, word k at the end of cycle (k+1)*CYC_PER_WORD of the erase.
- R5: While an erase runs, address bytes and every command byte except 70h and FFh are dropped. No other block is touched, the erase length is unchanged, and status-read mode stays on.
- R6: The status byte has bit 6 = ready (1 when not busy), bit 0 = fail, all other bits 0. Command 70h makes `dout` show it, busy or not. Any accepted command other than 70h/FFh/D0h sets `dout` back to 0. When an erase ends, `rb` is 1 and bit 6 reads 1.
- R7: Status bit 0 reads 0 after an erase with `fail_inj` low and 1 after an erase with `fail_inj` high at its last cycle. It keeps that value until the next erase end or reset.
- R8: FFh during an erase aborts it. Words whose slot has already ended hold all ones and later words keep their old data. `rb` stays low for RST_ABORT_CYC cycles, then the status reads 40h.
- R9: FFh outside an erase, when the interface is not in its reset state, holds `rb` low for RST_IDLE_CYC cycles. It clears the fail bit and status-read mode.
- R10: The interface is in its reset state after `rst_n` and after a reset interval ends, until a command other than 70h or FFh is accepted. An FFh in that state is dropped: `rb` stays 1 and status-read mode stays as it was.
- R11: After 60h, a command other than D0h, or D0h after two or four address bytes, returns to idle without an erase: `rb` stays 1 and no word changes.
- R12: A load strobe writes `ld_data` into the word at (`ld_blk`, `ld_word`). `rd_data` shows the word at (`rd_blk`, `rd_word`) without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | Command latch: the strobed byte is a command |
| ale | input | 1 | Address latch: the strobed byte is an address byte |
| wr_stb | input | 1 | One-cycle write strobe (write-enable rising edge) |
| din | input | 8 | Bus byte |
| fail_inj | input | 1 | Forces the erase result to fail when high at the last erase cycle |
| rb | output | 1 | Ready (1) / busy (0) |
| dout | output | 8 | Status byte in status-read mode, else 0 |
| ld_we | input | 1 | Array load strobe |
| ld_blk | input | log2(NUM_BLOCKS) | Load block index |
| ld_word | input | log2(WORDS_PER_BLOCK) | Load word index |
| ld_data | input | WORD_W | Load data |
| rd_blk | input | log2(NUM_BLOCKS) | Read block index |
| rd_word | input | log2(WORDS_PER_BLOCK) | Read word index |
| rd_data | output | WORD_W | Word at the read index |

## Verification
The assertions assume that `cle` and `ale` are never both high during a strobe. They also assume that `wr_stb` lasts one cycle, and that `fail_inj` is steady across the last erase cycle. The bench drives every byte through one bus task that raises one latch only, with an idle cycle after each strobe. It changes `fail_inj` only while the block is idle. Random choices cover block, page bits, upper row bits, array contents and the fail flag. Array loads are issued only while no erase runs.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_RESET   = 8'hFF;

    // Bit position of the block field inside the assembled row number
    localparam int BLK_LSB = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ERASE,
        ST_RST
    } fe_state_e;

endpackage

// File: rtl/fe_blk_array.sv
module fe_blk_array #(
    parameter int NUM_BLOCKS      = 8,
    parameter int WORDS_PER_BLOCK = 4,
    parameter int WORD_W          = 8,
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int WW = (WORDS_PER_BLOCK > 1) ? $clog2(WORDS_PER_BLOCK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              er_we,
    input  logic [BW-1:0]     er_blk,
    input  logic [WW-1:0]     er_word,
    input  logic              ld_we,
    input  logic [BW-1:0]     ld_blk,
    input  logic [WW-1:0]     ld_word,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [BW-1:0]     rd_blk,
    input  logic [WW-1:0]     rd_word,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [NUM_BLOCKS][WORDS_PER_BLOCK];
    logic [WORD_W-1:0] mem_d [NUM_BLOCKS][WORDS_PER_BLOCK];

    always_comb begin
        mem_d = mem_q;
        if (ld_we) begin
            mem_d[ld_blk][ld_word] = ld_data;
        end
        // erase wins over a load to the same word
        if (er_we) begin
            mem_d[er_blk][er_word] = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                for (int w = 0; w < WORDS_PER_BLOCK; w++) begin
                    mem_q[b][w] <= '1;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_blk][rd_word];

    p_erase_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        er_we |=> (mem_q[$past(er_blk)][$past(er_word)] == '1))
        else $error("erased word is not all ones");

    p_load_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !(er_we && er_blk == ld_blk && er_word == ld_word))
        |=> (mem_q[$past(ld_blk)][$past(ld_word)] == $past(ld_data)))
        else $error("loaded word not stored");

endmodule

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq
    import fe_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int WORDS_PER_BLOCK = 4,
    parameter int CYC_PER_WORD    = 8,
    parameter int RST_IDLE_CYC    = 4,
    parameter int RST_ABORT_CYC   = 12,
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int WW = (WORDS_PER_BLOCK > 1) ? $clog2(WORDS_PER_BLOCK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cle,
    input  logic          ale,
    input  logic          wr_stb,
    input  logic [7:0]    din,
    input  logic          fail_inj,
    output logic          rb,
    output logic [7:0]    dout,
    output logic          er_we,
    output logic [BW-1:0] er_blk,
    output logic [WW-1:0] er_word
);

    localparam int ERASE_CYC = WORDS_PER_BLOCK * CYC_PER_WORD;
    localparam int MAX_A     = (ERASE_CYC > RST_ABORT_CYC) ? ERASE_CYC : RST_ABORT_CYC;
    localparam int MAX_C     = (MAX_A > RST_IDLE_CYC) ? MAX_A : RST_IDLE_CYC;
    localparam int CW        = $clog2(MAX_C + 1);

    localparam logic [CW-1:0] CPW_C      = CW'(CYC_PER_WORD);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] RIDLE_LEN  = CW'(RST_IDLE_CYC);
    localparam logic [CW-1:0] RABRT_LEN  = CW'(RST_ABORT_CYC);
    localparam logic [CW-1:0] ONE_C      = CW'(1);

    typedef struct packed {
        fe_state_e     st;
        logic [2:0]    acnt;     // address bytes seen, saturates at 4
        logic [BW-1:0] blk;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          fail;
        logic          smode;    // status-read mode
        logic          rst_done; // in reset state
    } seq_t;

    seq_t cur_q, nxt_d;
    logic cmd_v, adr_v, slot_end;

    assign cmd_v    = wr_stb & cle & ~ale;
    assign adr_v    = wr_stb & ale & ~cle;
    assign slot_end = (cur_q.cnt % CPW_C) == (CPW_C - ONE_C);

    always_comb begin
        nxt_d = cur_q;
        er_we = 1'b0;
        case (cur_q.st)
            ST_IDLE, ST_ADDR: begin
                if (adr_v && cur_q.st == ST_ADDR) begin
                    for (int i = 0; i < BW; i++) begin
                        if ((BLK_LSB + i) / 8 == int'(cur_q.acnt)) begin
                            nxt_d.blk[i] = din[(BLK_LSB + i) % 8];
                        end
                    end
                    if (cur_q.acnt != 3'd4) begin
                        nxt_d.acnt = cur_q.acnt + 3'd1;
                    end
                end
                if (cmd_v) begin
                    if (cur_q.st == ST_ADDR && din == CMD_CONFIRM && cur_q.acnt == 3'd3) begin
                        nxt_d.st  = ST_ERASE;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.st   = ST_IDLE;
                        nxt_d.acnt = '0;
                        case (din)
                            CMD_SETUP: begin
                                nxt_d.st       = ST_ADDR;
                                nxt_d.blk      = '0;
                                nxt_d.smode    = 1'b0;
                                nxt_d.rst_done = 1'b0;
                            end
                            CMD_STATUS: nxt_d.smode = 1'b1;
                            CMD_RESET: begin
                                if (!cur_q.rst_done) begin
                                    nxt_d.st    = ST_RST;
                                    nxt_d.cnt   = '0;
                                    nxt_d.lim   = RIDLE_LEN;
                                    nxt_d.fail  = 1'b0;
                                    nxt_d.smode = 1'b0;
                                end
                            end
                            default: begin
                                nxt_d.smode    = 1'b0;
                                nxt_d.rst_done = 1'b0;
                            end
                        endcase
                    end
                end
            end
            ST_ERASE: begin
                nxt_d.cnt = cur_q.cnt + ONE_C;
                er_we     = slot_end;
                if (cur_q.cnt == ERASE_LAST) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.cnt  = '0;
                    nxt_d.fail = fail_inj;
                end
                if (cmd_v && din == CMD_STATUS) begin
                    nxt_d.smode = 1'b1;
                end else if (cmd_v && din == CMD_RESET) begin
                    er_we       = 1'b0;
                    nxt_d.st    = ST_RST;
                    nxt_d.cnt   = '0;
                    nxt_d.lim   = RABRT_LEN;
                    nxt_d.fail  = 1'b0;
                    nxt_d.smode = 1'b0;
                end
            end
            ST_RST: begin
                nxt_d.cnt = cur_q.cnt + ONE_C;
                if (cur_q.cnt == cur_q.lim - ONE_C) begin
                    nxt_d.st       = ST_IDLE;
                    nxt_d.cnt      = '0;
                    nxt_d.rst_done = 1'b1;
                end
                if (cmd_v && din == CMD_STATUS) begin
                    nxt_d.smode = 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.st       <= ST_IDLE;
            cur_q.rst_done <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign er_blk  = cur_q.blk;
    assign er_word = WW'(cur_q.cnt / CPW_C);
    assign rb      = !(cur_q.st == ST_ERASE || cur_q.st == ST_RST);
    assign dout    = cur_q.smode ? {1'b0, rb, 5'b00000, cur_q.fail} : 8'h00;

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ADDR && cmd_v && din == CMD_CONFIRM && cur_q.acnt == 3'd3) |=> !rb)
        else $error("erase did not start on confirm");

    p_bad_confirm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ADDR && cmd_v && din == CMD_CONFIRM && cur_q.acnt != 3'd3)
        |=> (rb && cur_q.st == ST_IDLE))
        else $error("confirm with wrong address count started work");

    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ERASE && cmd_v && din != CMD_STATUS && din != CMD_RESET
         && cur_q.cnt != ERASE_LAST) |=> (cur_q.st == ST_ERASE))
        else $error("command accepted during erase");

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ERASE && cmd_v && din == CMD_RESET)
        |=> (cur_q.st == ST_RST && !rb && cur_q.lim == RABRT_LEN))
        else $error("reset did not abort erase");

    p_rst_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE && cur_q.rst_done && cmd_v && din == CMD_RESET) |=> rb)
        else $error("repeated reset was accepted");

    p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ERASE && cur_q.cnt == ERASE_LAST && !(cmd_v && din == CMD_RESET))
        |=> (rb && (!cur_q.smode || dout[6])))
        else $error("ready not raised at erase end");

    p_fail_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ERASE && cur_q.cnt == ERASE_LAST && !(cmd_v && din == CMD_RESET))
        |=> (cur_q.fail == $past(fail_inj)))
        else $error("fail bit does not follow injected result");

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
    parameter int NUM_BLOCKS      = 8,
    parameter int WORDS_PER_BLOCK = 4,
    parameter int WORD_W          = 8,
    parameter int CYC_PER_WORD    = 8,
    parameter int RST_IDLE_CYC    = 4,
    parameter int RST_ABORT_CYC   = 12,
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int WW = (WORDS_PER_BLOCK > 1) ? $clog2(WORDS_PER_BLOCK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              wr_stb,
    input  logic [7:0]        din,
    input  logic              fail_inj,
    output logic              rb,
    output logic [7:0]        dout,
    input  logic              ld_we,
    input  logic [BW-1:0]     ld_blk,
    input  logic [WW-1:0]     ld_word,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [BW-1:0]     rd_blk,
    input  logic [WW-1:0]     rd_word,
    output logic [WORD_W-1:0] rd_data
);

    logic          er_we;
    logic [BW-1:0] er_blk;
    logic [WW-1:0] er_word;

    fe_cmd_seq #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .WORDS_PER_BLOCK (WORDS_PER_BLOCK),
        .CYC_PER_WORD    (CYC_PER_WORD),
        .RST_IDLE_CYC    (RST_IDLE_CYC),
        .RST_ABORT_CYC   (RST_ABORT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cle      (cle),
        .ale      (ale),
        .wr_stb   (wr_stb),
        .din      (din),
        .fail_inj (fail_inj),
        .rb       (rb),
        .dout     (dout),
        .er_we    (er_we),
        .er_blk   (er_blk),
        .er_word  (er_word)
    );

    fe_blk_array #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .WORDS_PER_BLOCK (WORDS_PER_BLOCK),
        .WORD_W          (WORD_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .er_we   (er_we),
        .er_blk  (er_blk),
        .er_word (er_word),
        .ld_we   (ld_we),
        .ld_blk  (ld_blk),
        .ld_word (ld_word),
        .ld_data (ld_data),
        .rd_blk  (rd_blk),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_flash_erase_ctl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctl;

    localparam int NB   = 8;
    localparam int WPB  = 4;
    localparam int CPW  = 8;
    localparam int RIDL = 4;
    localparam int RABT = 12;
    localparam int ECYC = WPB * CPW;
    localparam int BW   = 3;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cle = 1'b0, ale = 1'b0, wr_stb = 1'b0, fail_inj = 1'b0, ld_we = 1'b0;
    logic [7:0] din = 8'h00, ld_data = 8'h00, rd_data, dout;
    logic [2:0] ld_blk = '0, rd_blk = '0;
    logic [1:0] ld_word = '0, rd_word = '0;
    logic       rb;

    int cyc = 0, n_chk = 0, n_fail = 0;
    logic [7:0] mdl [NB][WPB];

    flash_erase_ctl dut (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wr_stb(wr_stb), .din(din),
        .fail_inj(fail_inj), .rb(rb), .dout(dout), .ld_we(ld_we), .ld_blk(ld_blk),
        .ld_word(ld_word), .ld_data(ld_data), .rd_blk(rd_blk), .rd_word(rd_word),
        .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] exp_status(bit rdy, bit fl);
        return {1'b0, rdy, 5'b00000, fl};
    endfunction

    function automatic logic [23:0] make_row(int blk, int page, int hi);
        return 24'((hi << (6 + BW)) | (blk << 6) | (page & 63));
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(bit c, bit a, logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; din = b; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(logic [7:0] b);  bus(1'b1, 1'b0, b); endtask
    task automatic addr(logic [7:0] b); bus(1'b0, 1'b1, b); endtask

    task automatic load_word(int b, int w, logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_blk = 3'(b); ld_word = 2'(w); ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
        mdl[b][w] = d;
    endtask

    task automatic read_word(int b, int w, output logic [7:0] d);
        rd_blk = 3'(b); rd_word = 2'(w);
        #0.1;
        d = rd_data;
    endtask

    task automatic check_mem(string req);
        logic [7:0] d;
        for (int b = 0; b < NB; b++) begin
            for (int w = 0; w < WPB; w++) begin
                read_word(b, w, d);
                check(req, d, mdl[b][w]);
            end
        end
    endtask

    task automatic wait_rdy(int t0, output int n);
        int g = 0;
        while (!rb && g < 5000) begin
            @(negedge clk);
            g++;
        end
        n = cyc - t0;
    endtask

    task automatic setup_erase(int blk, int page, int hi);
        logic [23:0] row = make_row(blk, page, hi);
        cmd(8'h60);
        addr(row[7:0]); addr(row[15:8]); addr(row[23:16]);
    endtask

    task automatic do_erase(int blk, int page, int hi, bit fl, string req);
        int t0, n;
        setup_erase(blk, page, hi);
        fail_inj = fl;
        cmd(8'hD0);
        t0 = cyc;
        check({req, " R3 busy right after confirm"}, rb, 0);
        wait_rdy(t0, n);
        check({req, " R3 busy length"}, n, ECYC);
        fail_inj = 1'b0;
        for (int w = 0; w < WPB; w++) mdl[blk][w] = 8'hFF;
        check_mem({req, " R4 array after erase"});
        cmd(8'h70);
        check({req, " R6/R7 status after erase"}, dout, exp_status(1'b1, fl));
        cmd(8'h00);
    endtask

    task automatic fill_random();
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < WPB; w++)
                load_word(b, w, 8'($urandom_range(0, 254)));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int t0, n;
        logic [7:0] d;
        void'($urandom(32'd1357));
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < WPB; w++) mdl[b][w] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rb after reset", rb, 1);
        check("R1 dout after reset", dout, 0);
        check_mem("R1 array all ones");
        cmd(8'h70);
        check("R1 status after reset", dout, 8'h40);

        // R10 reset right after power-on is dropped
        cmd(8'hFF);
        for (int k = 0; k < 4; k++) begin
            check("R10 rb stays high", rb, 1);
            @(negedge clk);
        end
        check("R10 status mode kept", dout, 8'h40);
        cmd(8'h00);
        check("R6 other command leaves status mode", dout, 0);

        // R9 reset from idle
        cmd(8'hFF);
        t0 = cyc;
        wait_rdy(t0, n);
        check("R9 idle reset length", n, RIDL);
        cmd(8'hFF);
        @(negedge clk);
        check("R10 second reset dropped", rb, 1);

        // R12 load and read
        load_word(2, 1, 8'h5A);
        read_word(2, 1, d);
        check("R12 readback", d, 8'h5A);
        load_word(7, 3, 8'h00);
        read_word(7, 3, d);
        check("R12 readback zero", d, 8'h00);

        fill_random();
        do_erase(3, 42, 5, 1'b0, "directed R2");

        // R7 failed erase, fail bit held, cleared by reset (R9)
        do_erase(0, 63, 32767, 1'b1, "fail");
        cmd(8'h70);
        check("R7 fail bit held", dout, 8'h41);
        cmd(8'hFF);
        t0 = cyc;
        wait_rdy(t0, n);
        check("R9 reset length", n, RIDL);
        check("R9 status mode cleared", dout, 0);
        cmd(8'h70);
        check("R9 fail cleared", dout, 8'h40);
        cmd(8'h00);

        // R5 commands during erase are dropped
        setup_erase(6, 1, 100);
        cmd(8'hD0);
        t0 = cyc;
        cmd(8'h70);
        check("R5 busy status", dout, 8'h00);
        cmd(8'h00);
        check("R5 status mode kept", dout, 8'h00);
        setup_erase(7, 0, 0);
        cmd(8'hD0);
        cmd(8'h30);
        addr(8'hC0);
        wait_rdy(t0, n);
        check("R5 erase length unchanged", n, ECYC);
        for (int w = 0; w < WPB; w++) mdl[6][w] = 8'hFF;
        check_mem("R5 only target erased");
        check("R5 R6 ready in status", dout, 8'h40);
        cmd(8'h00);

        // R8 abort
        for (int w = 0; w < WPB; w++) load_word(5, w, 8'h00);
        setup_erase(5, 9, 7);
        cmd(8'hD0);
        repeat (10) @(negedge clk);
        cmd(8'hFF);
        t0 = cyc;
        check("R8 busy after abort", rb, 0);
        wait_rdy(t0, n);
        check("R8 abort reset length", n, RABT);
        mdl[5][0] = 8'hFF;
        check_mem("R8 partial erase");
        cmd(8'h70);
        check("R8 status after abort", dout, 8'h40);
        cmd(8'h00);

        // R11 malformed sequences
        setup_erase(1, 0, 0);
        cmd(8'h30);
        cmd(8'hD0);
        @(negedge clk);
        check("R11 wrong confirm", rb, 1);
        cmd(8'h60); addr(8'h40); addr(8'h00); cmd(8'hD0);
        @(negedge clk);
        check("R11 two address bytes", rb, 1);
        cmd(8'h60); addr(8'h40); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'hD0);
        @(negedge clk);
        check("R11 four address bytes", rb, 1);
        check_mem("R11 array untouched");

        // random erases
        for (int it = 0; it < 16; it++) begin
            int bsel = $urandom_range(0, NB - 1);
            for (int w = 0; w < WPB; w++) load_word(bsel, w, 8'($urandom_range(0, 254)));
            do_erase($urandom_range(0, NB - 1), $urandom_range(0, 63),
                     $urandom_range(0, 32767), 1'($urandom_range(0, 1)), "random R2");
        end

        summary();
        $finish;
    end

endmodule